// File: doc/BRIEF.md
# SPI Slave Register Bridge

This block is a mode-0 SPI slave that lives entirely in the system clock domain and converts framed serial transactions into accesses on a simple parallel register bus. The chip-select pin frames each transaction. A transaction opens with a 24-bit command header that gives the transfer direction, the address policy (stepping or fixed), a 14-bit word count and an 8-bit start address. One to 16384 data words of 16 bits follow. In a write, each received word becomes one write strobe on the register bus. In a read, words are fetched from the register bus and shifted out on MISO.

The serial pins are oversampled. SCLK, MOSI and chip select each pass through a two-flop synchronizer, and SCLK edges are found by comparing successive synchronized samples. For this reason the system clock must run at least eight times faster than SCLK. Read data is expected in the same cycle as the read strobe.

Top module: `spi_reg_bridge`

## Requirements
- R1: Bits are sampled on rising SCLK edges, most significant bit first. Header bit 23 selects write (1) or read (0). Bit 22 selects a stepping address (1) or a fixed address (0). Bits 21..8 hold the word count minus one. Bits 7..0 hold the start address.
- R2: In a write, `reg_wr` is high for exactly one system cycle after the 16th bit of each data word. During that cycle `reg_wdata` holds the word, first bit in the MSB, and `reg_addr` holds the word's target address.
- R3: In a stepping burst, word i targets start address + i modulo 256, so the address wraps from 0xFF to 0x00.
- R4: In a fixed burst, every word targets the start address.
- R5: Exactly count+1 data words are transferred. Further SCLK bits in the same frame cause no strobe.
- R6: In a read, the first word is fetched (one-cycle `reg_rd` pulse) right after the last header bit. Each word's MSB is on MISO before that word's first rising SCLK edge, and later bits follow on falling edges.
- R7: A read frame issues exactly count+1 `reg_rd` pulses. Each later word is fetched when the 16th bit of the previous word arrives.
- R8: Raising chip select aborts the frame at any point. A partly received word is discarded, and the next frame starts with a fresh header.
- R9: MISO is low whenever the block is not shifting out read data: in the header, during writes, after the last word, and while deselected.
- R10: After reset, `miso`, `reg_wr` and `reg_rd` are low.
- R11: `reg_wr` and `reg_rd` are never high in the same cycle, and neither is high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI clock, idles low |
| mosi | input | 1 | Serial data from the master |
| cs_n | input | 1 | Active-low frame select |
| miso | output | 1 | Serial read data to the master |
| reg_addr | output | 8 | Register bus address |
| reg_wdata | output | 16 | Register bus write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 16 | Read data, valid in the `reg_rd` cycle |

## Verification
Two events land in the same system cycle: the final data word's strobe (a write, or the end of fetching) and the frame's switch to its finished state, which must silence any later SCLK bits. A second coincidence is the read fetch of the next word together with the address step that sets up the word after it. The bench provokes both with a sweep over word counts 0 to 3 in both address modes, and with frames that overrun their count. It judges them by the exact number of strobes, the address sequence (including the 0xFF to 0x00 wrap) and a MISO that stays low after the last word.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  localparam int HDR_BITS  = 24;
  localparam int WORD_BITS = 16;
  localparam int ADDR_BITS = 8;
  localparam int CNT_BITS  = 14;
  localparam int BIT_CNT_W = $clog2(HDR_BITS);

  // Header layout, MSB first on the wire
  typedef struct packed {
    logic                 wr;
    logic                 step;
    logic [CNT_BITS-1:0]  cnt;
    logic [ADDR_BITS-1:0] addr;
  } hdr_t;

  // Address for the next word of a burst
  function automatic logic [ADDR_BITS-1:0] next_addr(
    input logic [ADDR_BITS-1:0] a,
    input logic                 step
  );
    return step ? a + 1'b1 : a;
  endfunction

  // True when no further words remain after the current one
  function automatic logic is_last(input logic [CNT_BITS-1:0] left);
    return left == '0;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_bridge_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_s,
  input  logic                 mosi_s,
  input  logic                 csn_s,
  output logic [ADDR_BITS-1:0] reg_addr,
  output logic [WORD_BITS-1:0] reg_wdata,
  output logic                 reg_wr,
  output logic                 reg_rd,
  output logic                 rd_phase,
  output logic                 sclk_fall,
  output logic                 mid_word,
  output logic                 hdr_done,
  output logic                 hdr_is_rd,
  output logic                 word_done,
  output logic                 frame_done,
  output logic                 burst_step
);

  typedef enum logic [1:0] {ST_HDR, ST_DATA, ST_DONE} st_e;

  st_e                  state;
  logic                 sclk_q;
  logic                 sclk_rise;
  logic [BIT_CNT_W-1:0] bit_cnt;
  logic [HDR_BITS-2:0]  hdr_sr;
  logic [WORD_BITS-2:0] dat_sr;
  hdr_t                 hdr_next;
  logic [WORD_BITS-1:0] word_next;
  logic                 is_wr;
  logic                 step_q;
  logic [CNT_BITS-1:0]  left;
  logic [ADDR_BITS-1:0] cur_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  assign sclk_rise  = sclk_s & ~sclk_q & ~csn_s;
  assign sclk_fall  = ~sclk_s & sclk_q & ~csn_s;
  assign hdr_next   = hdr_t'({hdr_sr, mosi_s});
  assign word_next  = {dat_sr, mosi_s};
  assign hdr_done   = sclk_rise && (state == ST_HDR) &&
                      (bit_cnt == BIT_CNT_W'(HDR_BITS - 1));
  assign hdr_is_rd  = hdr_done && !hdr_next.wr;
  assign word_done  = sclk_rise && (state == ST_DATA) &&
                      (bit_cnt == BIT_CNT_W'(WORD_BITS - 1));
  assign mid_word   = (state == ST_DATA) && (bit_cnt != '0);
  assign rd_phase   = (state == ST_DATA) && !is_wr;
  assign frame_done = (state == ST_DONE);
  assign burst_step = step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_HDR;
      bit_cnt   <= '0;
      hdr_sr    <= '0;
      dat_sr    <= '0;
      is_wr     <= 1'b0;
      step_q    <= 1'b0;
      left      <= '0;
      cur_addr  <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (csn_s) begin
        state   <= ST_HDR;
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        unique case (state)
          ST_HDR: begin
            hdr_sr <= {hdr_sr[HDR_BITS-3:0], mosi_s};
            if (hdr_done) begin
              bit_cnt <= '0;
              state   <= ST_DATA;
              is_wr   <= hdr_next.wr;
              step_q  <= hdr_next.step;
              left    <= hdr_next.cnt;
              if (hdr_next.wr) begin
                cur_addr <= hdr_next.addr;
              end else begin
                reg_addr <= hdr_next.addr;
                reg_rd   <= 1'b1;
                cur_addr <= next_addr(hdr_next.addr, hdr_next.step);
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_DATA: begin
            dat_sr <= {dat_sr[WORD_BITS-3:0], mosi_s};
            if (word_done) begin
              bit_cnt <= '0;
              if (is_wr) begin
                reg_addr  <= cur_addr;
                reg_wdata <= word_next;
                reg_wr    <= 1'b1;
                cur_addr  <= next_addr(cur_addr, step_q);
              end else if (!is_last(left)) begin
                reg_addr <= cur_addr;
                reg_rd   <= 1'b1;
                cur_addr <= next_addr(cur_addr, step_q);
              end
              if (is_last(left)) state <= ST_DONE;
              else               left  <= left - 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift,
  input  logic         enable,
  output logic         miso
);

  logic [W-1:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_sr <= '0;
    else if (load)  tx_sr <= load_data;
    else if (shift) tx_sr <= {tx_sr[W-2:0], 1'b0};
  end

  assign miso = enable & tx_sr[W-1];

endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
  import spi_bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 mosi,
  input  logic                 cs_n,
  output logic                 miso,
  output logic [ADDR_BITS-1:0] reg_addr,
  output logic [WORD_BITS-1:0] reg_wdata,
  output logic                 reg_wr,
  output logic                 reg_rd,
  input  logic [WORD_BITS-1:0] reg_rdata
);

  logic [2:0] pins_s;
  logic       sclk_s, mosi_s, csn_s;
  logic       rd_phase, sclk_fall, mid_word;
  logic       hdr_done, hdr_is_rd, word_done, frame_done, burst_step;
  logic       tx_shift;

  spi_pin_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({cs_n, mosi, sclk}),
    .dout (pins_s)
  );

  assign sclk_s = pins_s[0];
  assign mosi_s = pins_s[1];
  assign csn_s  = pins_s[2];

  spi_frame_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (sclk_s),
    .mosi_s    (mosi_s),
    .csn_s     (csn_s),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .rd_phase  (rd_phase),
    .sclk_fall (sclk_fall),
    .mid_word  (mid_word),
    .hdr_done  (hdr_done),
    .hdr_is_rd (hdr_is_rd),
    .word_done (word_done),
    .frame_done(frame_done),
    .burst_step(burst_step)
  );

  assign tx_shift = sclk_fall && mid_word && rd_phase;

  spi_tx_shift #(.W(WORD_BITS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reg_rd),
    .load_data(reg_rdata),
    .shift    (tx_shift),
    .enable   (rd_phase),
    .miso     (miso)
  );

endmodule

// File: rtl/spi_reg_bridge_chk.sv
module spi_reg_bridge_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csn_s,
  input logic          miso,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic          hdr_done,
  input logic          hdr_is_rd,
  input logic          word_done,
  input logic          frame_done,
  input logic          burst_step
);

  logic          seen_wr;
  logic [AW-1:0] last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_wr   <= 1'b0;
      last_addr <= '0;
    end else if (hdr_done) begin
      seen_wr <= 1'b0;
    end else if (reg_wr) begin
      seen_wr   <= 1'b1;
      last_addr <= reg_addr;
    end
  end

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  p_rd_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  p_step_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && seen_wr && burst_step) |-> (reg_addr == AW'(last_addr + 1'b1)));

  p_fixed_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && seen_wr && !burst_step) |-> (reg_addr == last_addr));

  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && $past(frame_done)) |-> !(reg_wr || reg_rd || word_done));

  p_first_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_is_rd |=> reg_rd);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !(reg_wr || reg_rd));

  p_miso_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !miso);

endmodule

bind spi_reg_bridge spi_reg_bridge_chk #(.AW(spi_bridge_pkg::ADDR_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .csn_s     (csn_s),
  .miso      (miso),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .hdr_done  (hdr_done),
  .hdr_is_rd (hdr_is_rd),
  .word_done (word_done),
  .frame_done(frame_done),
  .burst_step(burst_step)
);

// File: tb/spi_reg_bridge_tb.sv
module spi_reg_bridge_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;   // system cycles per SCLK half period
  localparam int LOGN       = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic cs_n = 1'b1;
  logic        miso;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        reg_wr, reg_rd;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .miso(miso), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  // Bus model and strobe log (only this process writes these)
  logic [15:0] mem [256];
  int          wn = 0;
  int          rn = 0;
  logic [7:0]  wa [LOGN];
  logic [15:0] wd [LOGN];
  logic [7:0]  ra [LOGN];
  logic        both_seen = 1'b0;

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_wr && reg_rd) both_seen = 1'b1;
    if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
      wa[wn % LOGN] = reg_addr;
      wd[wn % LOGN] = reg_wdata;
      wn++;
    end
    if (reg_rd) begin
      ra[rn % LOGN] = reg_addr;
      rn++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int a, input int i);
    return 16'((a * 257) ^ (i * 4951) ^ 16'hA5C3);
  endfunction

  logic miso_seen;

  task automatic xbit(input logic b, output logic r);
    mosi = b;
    repeat (HALF) @(negedge clk);
    r = miso;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic cs_begin();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (3*HALF) @(negedge clk);
  endtask

  task automatic xhdr(input logic wr, input logic step, input logic [13:0] cnt,
                      input logic [7:0] addr);
    logic [23:0] h;
    logic r;
    h = {wr, step, cnt, addr};
    for (int i = 23; i >= 0; i--) begin
      xbit(h[i], r);
      miso_seen |= r;
    end
  endtask

  task automatic xword(input logic [15:0] w, output logic [15:0] got);
    logic r;
    for (int i = 15; i >= 0; i--) begin
      xbit(w[i], r);
      got[i] = r;
    end
  endtask

  initial begin
    logic [15:0] got;
    int w0, r0, base;
    repeat (5) @(negedge clk);
    // R10: reset state
    chk("R10", "miso", int'(miso), 0);
    chk("R10", "reg_wr", int'(reg_wr), 0);
    chk("R10", "reg_rd", int'(reg_rd), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Sweep: both address modes, counts 0..3, write then read back
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 4; c++) begin
        base = (m == 1) ? 8'hFE : (8'h40 + c * 8);
        w0 = wn;
        miso_seen = 1'b0;
        cs_begin();
        xhdr(1'b1, m[0], 14'(c), 8'(base));
        for (int i = 0; i <= c; i++) begin
          xword(pat(base, i), got);
          miso_seen |= |got;
        end
        cs_end();
        chk("R5", "write strobes", wn - w0, c + 1);
        chk("R9", "miso during write", int'(miso_seen), 0);
        for (int i = 0; i <= c; i++) begin
          // R1 header address decode; R3 stepping with wrap; R4 fixed
          chk(m ? "R3" : "R4", "write addr", int'(wa[(w0 + i) % LOGN]),
              m ? ((base + i) % 256) : base);
          chk("R2", "write data", int'(wd[(w0 + i) % LOGN]), int'(pat(base, i)));
        end
        r0 = rn;
        miso_seen = 1'b0;
        cs_begin();
        xhdr(1'b0, m[0], 14'(c), 8'(base));
        chk("R9", "miso in read header", int'(miso_seen), 0);
        for (int i = 0; i <= c; i++) begin
          xword(16'h0000, got);
          chk("R6", "read word", int'(got), int'(m ? pat(base, i) : pat(base, c)));
        end
        cs_end();
        chk("R7", "read strobes", rn - r0, c + 1);
        for (int i = 0; i <= c; i++)
          chk(m ? "R3" : "R4", "read addr", int'(ra[(r0 + i) % LOGN]),
              m ? ((base + i) % 256) : base);
      end
    end

    // R5: write frame overrunning its count of two words
    w0 = wn;
    cs_begin();
    xhdr(1'b1, 1'b1, 14'd1, 8'h60);
    for (int i = 0; i < 4; i++) xword(pat(8'h60, i), got);
    cs_end();
    chk("R5", "overrun write strobes", wn - w0, 2);

    // R5/R9: read of one word followed by extra clocks keeps MISO low
    r0 = rn;
    cs_begin();
    xhdr(1'b0, 1'b1, 14'd0, 8'h60);
    xword(16'h0000, got);
    chk("R6", "single read word", int'(got), int'(pat(8'h60, 0)));
    xword(16'hFFFF, got);
    chk("R9", "miso after last word", int'(got), 0);
    xword(16'hFFFF, got);
    chk("R9", "miso after last word 2", int'(got), 0);
    cs_end();
    chk("R7", "single read strobes", rn - r0, 1);

    // R8: abort in the middle of the second data word
    w0 = wn;
    cs_begin();
    xhdr(1'b1, 1'b1, 14'd3, 8'h70);
    xword(16'h1234, got);
    for (int i = 0; i < 8; i++) begin
      logic r;
      xbit(1'b1, r);
    end
    cs_end();
    chk("R8", "strobes after abort", wn - w0, 1);
    chk("R8", "kept word", int'(wd[w0 % LOGN]), 16'h1234);

    // R8: abort inside the header, then a clean frame
    cs_begin();
    for (int i = 0; i < 10; i++) begin
      logic r;
      xbit(1'b1, r);
    end
    cs_end();
    w0 = wn;
    cs_begin();
    xhdr(1'b1, 1'b0, 14'd0, 8'h90);
    xword(16'hBEEF, got);
    cs_end();
    chk("R8", "fresh frame strobes", wn - w0, 1);
    chk("R8", "fresh frame addr", int'(wa[w0 % LOGN]), 8'h90);
    cs_begin();
    xhdr(1'b0, 1'b0, 14'd0, 8'h90);
    xword(16'h0000, got);
    cs_end();
    chk("R8", "fresh frame readback", int'(got), 16'hBEEF);

    chk("R11", "wr and rd together", int'(both_seen), 0);
    chk("R10", "miso idle at end", int'(miso), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule